// File: doc/BRIEF.md
# Compare-Match Timer with Prescaler and Input Filter

The block is a 16-bit up-counter that raises an event when it passes a programmed compare value. It has two counting sources. In time mode it counts ticks of one of four clock-enable inputs, either directly or after a power-of-two divider. In pulse mode it counts active edges on one of four external pins. A pulse-mode pin can pass through a glitch filter that accepts a new level only after that level has been seen on a programmable power-of-two number of consecutive filter samples. The filter samples on ticks of the selected clock-enable input.

The compare event does four things. It sets a sticky flag, emits a one-cycle trigger pulse, and drives an interrupt line and a DMA request line, each gated by its own enable bit. The counter can either restart from zero at every compare event or keep running and wrap on overflow. Software reaches the block through four 16-bit registers with single-cycle write strobes and a combinational read port. Software reads the live count by first writing the counter address, which copies the count into a holding register, and then reading that register.

Top module: `cmp_timer`

## Requirements
- R1: Addresses are control = 0, prescale = 1, compare = 2 and counter = 3. After reset every register reads 0, and `trig_o`, `irq_o` and `dma_req_o` are low.
- R2: In time mode (control bit 1 = 0) with the bypass bit (prescale bit 4) clear and a divider code N in prescale bits 3:0, the counter advances once per 2^(N+1) ticks of the selected clock-enable input. With bypass set, it advances once per tick.
- R3: Prescale bits 6:5 select which `src_en` bit acts as the tick or sample source. The other `src_en` bits have no effect on the count.
- R4: In pulse mode (control bit 1 = 1) the counter advances once per rising edge of the pin chosen by control bits 7:6. With the polarity bit (control bit 5) set, it advances once per falling edge instead. The other pins have no effect.
- R5: In pulse mode with bypass clear and code N ≥ 1, a new pin level is accepted only after 2^N consecutive samples at that level. Shorter pulses are not counted. Code 0, or bypass set, counts the pin unfiltered.
- R6: A counting tick that finds the counter equal to the compare value sets the flag (control bit 15) and produces a one-cycle high on `trig_o` in the same cycle. After enabling, the first event therefore lands on tick number compare+1.
- R7: With the free-run bit (control bit 2) clear, the counter returns to 0 at each compare event.
- R8: With free-run set, the counter keeps incrementing through the compare value and wraps from 0xFFFF to 0.
- R9: Writing 1 to control bit 15 clears the flag. Writing 0 there leaves the flag unchanged. A compare event in the same cycle as a clear leaves the flag set.
- R10: `irq_o` is high exactly when the flag and the interrupt-enable bit (control bit 3) are both set. `dma_req_o` is high exactly when the flag and the DMA-enable bit (control bit 4) are both set.
- R11: While the run bit (control bit 0) is 0, the counter stays at 0 and the divider and filter are held in their start state. A restarted run therefore begins a full division period.
- R12: A write to the counter address copies the live count into a holding register. Reads of the counter address return that held value, which does not follow later counting.
- R13: While the run bit is 1, writes to the prescale register are ignored, and so are writes to control bits 1, 5 and 7:6. The run, free-run and enable bits stay writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` (combinational) |
| src_en | input | 4 | Clock-enable ticks of the four divider/filter sources |
| pin_in | input | 4 | External pulse inputs |
| trig_o | output | 1 | One-cycle pulse on a compare event |
| irq_o | output | 1 | Interrupt request, flag gated by interrupt enable |
| dma_req_o | output | 1 | DMA request, flag gated by DMA enable |

## Verification
The assertions take `src_en` and `pin_in` to be synchronous to `clk`. They also assume that a given `src_en` bit is one clock-enable per cycle and not a clock. The step and reset-at-match properties rely on the compare value being held stable while a tick is in flight. The stimulus drives every input on the falling edge and changes the compare value only while the timer is stopped. It holds the selected pin at its inactive level whenever the run bit goes high, because a pin that is already active at start-up counts as one edge. The timing checks use a held-high source, so that the expected cycle of each event is the product of the compare value plus one and the division ratio.

// File: rtl/cmptmr_pkg.sv
`timescale 1ns/1ps
package cmptmr_pkg;
   localparam int NUM_IN = 4;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_PRE  = 2'd1;
   localparam logic [1:0] A_CMP  = 2'd2;
   localparam logic [1:0] A_CNT  = 2'd3;

   // control register bit positions
   localparam int B_RUN   = 0;
   localparam int B_PULSE = 1;
   localparam int B_FREE  = 2;
   localparam int B_IRQE  = 3;
   localparam int B_DMAE  = 4;
   localparam int B_POL   = 5;
   localparam int B_PSEL  = 6;
   localparam int B_FLAG  = 15;

   // prescale register bit positions (code occupies the low bits)
   localparam int B_BYP   = 4;
   localparam int B_CSEL  = 5;
endpackage

// File: rtl/cmptmr_prescale.sv
`timescale 1ns/1ps
module cmptmr_prescale #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              src_tick,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   localparam int PS_W = 1 << CODE_W;

   if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code
      $error("cmptmr_prescale: CODE_W must be 1..4");
   end

   logic [PS_W-1:0]   div_q;
   logic [PS_W-1:0]   lim;
   logic [CODE_W:0]   sh;

   always_comb begin
      sh   = {1'b0, code} + (CODE_W+1)'(1);
      lim  = ~({PS_W{1'b1}} << sh);
      tick = src_tick && (div_q == lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_q <= '0;
      else if (clr)      div_q <= '0;
      else if (src_tick) div_q <= tick ? '0 : div_q + PS_W'(1);
   end

   AST_PRE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (div_q == '0)); // R11
   AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && src_tick && !tick) |=> (div_q == $past(div_q) + PS_W'(1))); // R2
endmodule

// File: rtl/cmptmr_glitch.sv
`timescale 1ns/1ps
module cmptmr_glitch #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              sample,
   input  logic              raw,
   input  logic [CODE_W-1:0] code,
   output logic              level
);
   localparam int PS_W = 1 << CODE_W;

   if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code
      $error("cmptmr_glitch: CODE_W must be 1..4");
   end

   logic [PS_W-1:0] run_q;
   logic [PS_W-1:0] lim;

   always_comb lim = ~({PS_W{1'b1}} << code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= 1'b0;
         run_q <= '0;
      end else if (clr) begin
         level <= 1'b0;
         run_q <= '0;
      end else if (sample) begin
         if (raw == level) begin
            run_q <= '0;
         end else if (run_q == lim) begin
            level <= raw;
            run_q <= '0;
         end else begin
            run_q <= run_q + PS_W'(1);
         end
      end
   end

   AST_FLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !sample) |=> $stable(level)); // R5
   AST_FLT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && sample && (raw == level)) |=> (run_q == '0)); // R5
endmodule

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
module cmp_timer
   import cmptmr_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int CODE_W     = 4,
   parameter bit HAS_FILTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic [3:0]       src_en,
   input  logic [3:0]       pin_in,
   output logic             trig_o,
   output logic             irq_o,
   output logic             dma_req_o
);
   localparam int SEL_W = $clog2(NUM_IN);

   if (CNT_W < 16) begin : g_bad_width
      $error("cmp_timer: CNT_W must be at least 16");
   end
   if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code
      $error("cmp_timer: CODE_W must be 1..4");
   end

   logic             run_q, pulse_q, free_q, irqe_q, dmae_q, pol_q, byp_q;
   logic [SEL_W-1:0] psel_q, csel_q;
   logic [CODE_W-1:0] code_q;
   logic [CNT_W-1:0] cmp_q, cnt_q, snap_q;
   logic             flag_q, trig_q, lvl_q;

   logic wr_ctrl, wr_pre, wr_cmp, wr_cnt;
   logic src_tick, raw, pre_tick, flt_level, use_raw, level, edge_hit;
   logic count_tick, match, flag_set, flag_clr;
   logic unused_wdata;

   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign wr_pre  = bus_wr && (bus_addr == A_PRE);
   assign wr_cmp  = bus_wr && (bus_addr == A_CMP);
   assign wr_cnt  = bus_wr && (bus_addr == A_CNT);
   assign unused_wdata = ^bus_wdata;

   assign src_tick = src_en[csel_q];
   assign raw      = pin_in[psel_q] ^ pol_q;

   // configuration registers, locked fields only move while stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         pulse_q <= 1'b0;
         free_q  <= 1'b0;
         irqe_q  <= 1'b0;
         dmae_q  <= 1'b0;
         pol_q   <= 1'b0;
         psel_q  <= '0;
         code_q  <= '0;
         byp_q   <= 1'b0;
         csel_q  <= '0;
         cmp_q   <= '0;
      end else begin
         if (wr_ctrl) begin
            run_q  <= bus_wdata[B_RUN];
            free_q <= bus_wdata[B_FREE];
            irqe_q <= bus_wdata[B_IRQE];
            dmae_q <= bus_wdata[B_DMAE];
            if (!run_q) begin
               pulse_q <= bus_wdata[B_PULSE];
               pol_q   <= bus_wdata[B_POL];
               psel_q  <= bus_wdata[B_PSEL +: SEL_W];
            end
         end
         if (wr_pre && !run_q) begin
            code_q <= bus_wdata[CODE_W-1:0];
            byp_q  <= bus_wdata[B_BYP];
            csel_q <= bus_wdata[B_CSEL +: SEL_W];
         end
         if (wr_cmp) cmp_q <= bus_wdata;
      end
   end

   cmptmr_prescale #(.CODE_W(CODE_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!run_q || pulse_q),
      .src_tick (src_tick),
      .code     (code_q),
      .tick     (pre_tick)
   );

   if (HAS_FILTER) begin : g_flt
      cmptmr_glitch #(.CODE_W(CODE_W)) u_flt (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (!run_q || !pulse_q),
         .sample (src_tick),
         .raw    (raw),
         .code   (code_q),
         .level  (flt_level)
      );
   end else begin : g_noflt
      assign flt_level = raw;
   end

   assign use_raw  = byp_q || (code_q == '0) || !HAS_FILTER;
   assign level    = use_raw ? raw : flt_level;
   assign edge_hit = level && !lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 lvl_q <= 1'b0;
      else if (!run_q || !pulse_q) lvl_q <= 1'b0;
      else                        lvl_q <= level;
   end

   assign count_tick = run_q && (pulse_q ? edge_hit : (byp_q ? src_tick : pre_tick));
   assign match      = (cnt_q == cmp_q);
   assign flag_set   = count_tick && match;
   assign flag_clr   = wr_ctrl && bus_wdata[B_FLAG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
         trig_q <= 1'b0;
         snap_q <= '0;
      end else begin
         if (!run_q)
            cnt_q <= '0;
         else if (count_tick)
            cnt_q <= (match && !free_q) ? '0 : cnt_q + CNT_W'(1);
         flag_q <= flag_set || (flag_q && !flag_clr);
         trig_q <= flag_set;
         if (wr_cnt) snap_q <= cnt_q;
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL: begin
            bus_rdata[B_RUN]             = run_q;
            bus_rdata[B_PULSE]           = pulse_q;
            bus_rdata[B_FREE]            = free_q;
            bus_rdata[B_IRQE]            = irqe_q;
            bus_rdata[B_DMAE]            = dmae_q;
            bus_rdata[B_POL]             = pol_q;
            bus_rdata[B_PSEL +: SEL_W]   = psel_q;
            bus_rdata[B_FLAG]            = flag_q;
         end
         A_PRE: begin
            bus_rdata[CODE_W-1:0]        = code_q;
            bus_rdata[B_BYP]             = byp_q;
            bus_rdata[B_CSEL +: SEL_W]   = csel_q;
         end
         A_CMP:   bus_rdata = cmp_q;
         default: bus_rdata = snap_q;
      endcase
   end

   assign trig_o    = trig_q;
   assign irq_o     = flag_q && irqe_q;
   assign dma_req_o = flag_q && dmae_q;

   AST_TRIG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> flag_q); // R6
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr) |=> flag_q); // R9
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (count_tick && !match) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
   AST_MATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (count_tick && match && !free_q) |=> (cnt_q == '0)); // R7
   AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && bus_wr) |=> ($stable(code_q) && $stable(csel_q) && $stable(byp_q)
                             && $stable(pulse_q) && $stable(psel_q) && $stable(pol_q))); // R13
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |=> (cnt_q == '0)); // R11
   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt |=> $stable(snap_q)); // R12
endmodule

// File: tb/tb_cmp_timer.sv
`timescale 1ns/1ps
module tb_cmp_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [3:0]  src_en = '0;
   logic [3:0]  pin_in = '0;
   logic        trig_o, irq_o, dma_req_o;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk; // 50 MHz

   cmp_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_en(src_en),
      .pin_in(pin_in), .trig_o(trig_o), .irq_o(irq_o), .dma_req_o(dma_req_o)
   );

   function automatic logic [15:0] ctl(bit run, bit pulse, bit free, bit irqe,
                                       bit dmae, bit pol, logic [1:0] psel, bit fclr);
      logic [15:0] v = '0;
      v[0] = run; v[1] = pulse; v[2] = free; v[3] = irqe; v[4] = dmae;
      v[5] = pol; v[7:6] = psel; v[15] = fclr;
      return v;
   endfunction

   function automatic logic [15:0] pre(logic [3:0] code, bit byp, logic [1:0] csel);
      logic [15:0] v = '0;
      v[3:0] = code; v[4] = byp; v[6:5] = csel;
      return v;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic snap(output logic [15:0] d);
      wr(2'd3, 16'h0);
      rd(2'd3, d);
   endtask

   task automatic ticks(int idx, int n);
      @(negedge clk);
      src_en[idx] = 1'b1;
      repeat (n) @(negedge clk);
      src_en[idx] = 1'b0;
   endtask

   task automatic pulses(int idx, int hw, int lw, int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         pin_in[idx] = ~pin_in[idx];
         repeat (hw) @(negedge clk);
         pin_in[idx] = ~pin_in[idx];
         repeat (lw - 1) @(negedge clk);
      end
      repeat (10) @(negedge clk);
   endtask

   task automatic stop();
      wr(2'd0, ctl(0, 0, 0, 0, 0, 0, 2'd0, 1));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog R1-suite actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [15:0] d;
      int cyc, expn, dv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], d);
         chk("R1 register reset", d, 0);
      end
      chk("R1 trig reset", trig_o, 0);
      chk("R1 irq reset", irq_o, 0);
      chk("R1 dma reset", dma_req_o, 0);

      // R2 / R6 / R10: divider and compare timing sweep
      for (int b = 0; b < 2; b++) begin
         for (int n = 0; n < 4; n++) begin
            if (b == 1 && n > 0) continue;
            for (int c = 0; c < 3; c++) begin
               dv   = (b == 1) ? 1 : (2 << n);
               expn = (c + 1) * dv;
               stop();
               wr(2'd1, pre(n[3:0], b[0], 2'd1));
               wr(2'd2, c[15:0]);
               src_en = 4'b0010;
               wr(2'd0, ctl(1, 0, 0, 1, 0, 0, 2'd0, 0));
               cyc = 0;
               while (cyc < 2000) begin
                  @(negedge clk);
                  cyc++;
                  if (irq_o) break;
               end
               chk("R2 cycles to first compare", cyc, expn);
               chk("R6 trig with flag", trig_o, 1);
               chk("R10 dma gated off", dma_req_o, 0);
               if (expn > 1) begin
                  @(negedge clk);
                  chk("R6 trig one cycle", trig_o, 0);
               end
               src_en = 4'b0000;
            end
         end
      end
      stop();

      // R7 / R12: reset-on-match and snapshot
      wr(2'd1, pre(0, 1, 2'd0));
      wr(2'd2, 16'd2);
      wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 2'd0, 0));
      ticks(0, 10);
      snap(d);
      chk("R7 count after 10 ticks cmp 2", d, 1);
      rd(2'd0, d);
      chk("R6 flag set", d[15], 1);
      ticks(0, 2);
      rd(2'd3, d);
      chk("R12 held value stale", d, 1);
      snap(d);
      chk("R12 new snapshot", d, 0);

      // R11: stop clears counter
      stop();
      snap(d);
      chk("R11 counter zero when stopped", d, 0);

      // R8: free-running and wrap
      wr(2'd0, ctl(1, 0, 1, 0, 0, 0, 2'd0, 0));
      ticks(0, 10);
      snap(d);
      chk("R8 free-run passes compare", d, 10);
      stop();
      wr(2'd0, ctl(1, 0, 1, 0, 0, 0, 2'd0, 0));
      ticks(0, 65541);
      snap(d);
      chk("R8 wrap past 0xFFFF", d, 5);

      // R9 / R10: write-1-to-clear and gating
      wr(2'd0, ctl(1, 0, 1, 0, 1, 0, 2'd0, 0));
      rd(2'd0, d);
      chk("R9 write 0 keeps flag", d[15], 1);
      chk("R10 dma follows flag", dma_req_o, 1);
      chk("R10 irq gated off", irq_o, 0);
      wr(2'd0, ctl(1, 0, 1, 1, 0, 0, 2'd0, 1));
      rd(2'd0, d);
      chk("R9 write 1 clears flag", d[15], 0);
      chk("R10 irq low after clear", irq_o, 0);
      chk("R10 dma low after clear", dma_req_o, 0);

      // R11: divider restarts on re-enable
      stop();
      wr(2'd1, pre(1, 0, 2'd0));
      wr(2'd2, 16'hFFFF);
      wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 2'd0, 0));
      ticks(0, 3);
      stop();
      wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 2'd0, 0));
      ticks(0, 3);
      snap(d);
      chk("R11 divider restarted", d, 0);
      ticks(0, 1);
      snap(d);
      chk("R11 first divided tick", d, 1);

      // R13: locked fields while running
      wr(2'd1, pre(5, 1, 2'd2));
      rd(2'd1, d);
      chk("R13 prescale write ignored", d, pre(1, 0, 2'd0));
      wr(2'd0, ctl(1, 1, 0, 0, 0, 1, 2'd3, 0));
      rd(2'd0, d);
      chk("R13 mode/pol/sel write ignored", d, ctl(1, 0, 0, 0, 0, 0, 2'd0, 0));
      ticks(0, 4);
      snap(d);
      chk("R13 still time mode div 4", d, 2);

      // R3: source select
      stop();
      wr(2'd1, pre(0, 1, 2'd2));
      wr(2'd0, ctl(1, 0, 0, 0, 0, 0, 2'd0, 0));
      @(negedge clk);
      src_en = 4'b1011;
      repeat (10) @(negedge clk);
      src_en = 4'b0000;
      snap(d);
      chk("R3 unselected sources ignored", d, 0);
      ticks(2, 3);
      snap(d);
      chk("R3 selected source counts", d, 3);

      // R4: pulse mode, pin select and polarity
      stop();
      wr(2'd1, pre(0, 1, 2'd0));
      pin_in = 4'b0000;
      wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 2'd2, 0));
      pulses(2, 2, 2, 5);
      pulses(1, 2, 2, 3);
      pulses(3, 2, 2, 2);
      snap(d);
      chk("R4 rising edges of selected pin", d, 5);
      stop();
      pin_in = 4'b1111;
      wr(2'd0, ctl(1, 1, 0, 0, 0, 1, 2'd2, 0));
      pulses(2, 2, 2, 4);
      pulses(0, 2, 2, 2);
      snap(d);
      chk("R4 falling edges active-low", d, 4);
      stop();
      pin_in = 4'b0000;

      // R5: glitch filter
      wr(2'd1, pre(2, 0, 2'd0));
      src_en = 4'b0001;
      wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 2'd0, 0));
      pulses(0, 3, 8, 2);
      pulses(0, 4, 8, 1);
      pulses(0, 6, 8, 1);
      snap(d);
      chk("R5 filter code 2 rejects width 3", d, 2);
      stop();
      wr(2'd1, pre(0, 0, 2'd0));
      wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 2'd0, 0));
      pulses(0, 1, 1, 3);
      snap(d);
      chk("R5 code 0 unfiltered", d, 3);
      stop();
      wr(2'd1, pre(2, 1, 2'd0));
      wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 2'd0, 0));
      pulses(0, 1, 1, 3);
      snap(d);
      chk("R5 bypass unfiltered", d, 3);
      src_en = 4'b0000;
      stop();

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule